// File: doc/BRIEF.md
# Clock Status and Interrupt Flag Register

This block is the byte-wide status and flag register of a clock and reset generator. It takes in four conditions: a low-voltage-reset event pulse, the PLL lock indicator, the PLL track indicator and the self-clock-mode indicator. It shows them to software through one register on a simple synchronous bus. Three positions hold live status that software cannot write. Three positions hold sticky flags that software clears by writing 1.

The lock flag and the self-clock-mode flag are set by any change of their status bit, rising or falling. A flag is found by comparing the current status with a copy registered in the previous cycle. While self clock mode is active, the PLL lock and track bits are forced to 0. A lock flag can therefore come from entering self clock mode alone. The two change flags, each gated by its own enable input, drive one registered interrupt request.

Top module: `clk_stat_flags`

## Requirements
- R1: While `rst_n` is low, flags [4] and [1] and the interrupt output are 0 after the clock edge. Bits [7:6] always read 0.
- R2: Bit [4] (lock change flag) is set one cycle after the masked lock status differs from its value in the previous cycle, on either edge.
- R3: Bits [3] (lock) and [2] (track) follow `pll_lock_i` and `pll_track_i` combinationally, and both read 0 while `self_clk_i` is 1. Masking lock in this way counts as a lock change for R2.
- R4: Bit [0] follows `self_clk_i` combinationally. Bit [1] (self-clock change flag) is set one cycle after `self_clk_i` differs from its previous-cycle value, on either edge.
- R5: Bit [5] (low-voltage-reset flag) is set by `lvr_evt_i` at the next edge, in normal operation and also while `rst_n` is low. With `HAS_LVR` = 0 it always reads 0.
- R6: A write happens when `reg_sel_i` and `reg_wr_i` are both 1. A 1 in write data bit 5, 4 or 1 clears that flag at the next edge. A 0 leaves the flag unchanged. Written values of bits [3], [2] and [0] have no effect. A write with `reg_sel_i` = 0 does nothing.
- R7: When a set condition and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.
- R8: `irq_o` equals ((flag[4] AND `lock_irq_en_i`) OR (flag[1] AND `scm_irq_en_i`)), delayed by one register. It rises one cycle after a flag sets and falls one cycle after the flag clears or its enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lvr_evt_i | input | 1 | Low-voltage-reset event pulse |
| pll_lock_i | input | 1 | PLL lock condition |
| pll_track_i | input | 1 | PLL track condition (1 = tracking) |
| self_clk_i | input | 1 | Self clock mode active |
| reg_sel_i | input | 1 | Register address match |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| lock_irq_en_i | input | 1 | Lock change interrupt enable |
| scm_irq_en_i | input | 1 | Self-clock change interrupt enable |
| reg_rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drives both edges of lock and of self clock mode. A design that detects only rising edges would miss the flag on the falling edge.

It enters self clock mode while locked, so that the lock flag must come from masking alone. A detector that looks at the raw input instead of the masked status stays silent there. It also clears a flag in the same cycle that a new change sets it. A design that gives priority to the clear loses that event.

The bench writes 0 patterns, writes to the live-bit positions, and writes with no address match, and checks that each of these leaves the register unchanged. It follows the interrupt one cycle behind each flag and each enable change. A second instance with the low-voltage flag disabled shows bit 5 held at 0 while the event pulses.

// File: rtl/clk_stat_flags.sv
module clk_stat_flags #(
  parameter bit HAS_LVR = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvr_evt_i,
  input  logic       pll_lock_i,
  input  logic       pll_track_i,
  input  logic       self_clk_i,
  input  logic       reg_sel_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       lock_irq_en_i,
  input  logic       scm_irq_en_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);

  logic lock_m, track_m;
  logic lock_q, scm_q;
  logic lvr_f, lock_f, scm_f;
  logic irq_q;
  logic [7:0] clr;

  assign lock_m  = pll_lock_i  & ~self_clk_i;
  assign track_m = pll_track_i & ~self_clk_i;
  assign clr     = (reg_sel_i && reg_wr_i) ? reg_wdata_i : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      scm_q  <= 1'b0;
      lock_f <= 1'b0;
      scm_f  <= 1'b0;
      lvr_f  <= HAS_LVR & lvr_evt_i;
      irq_q  <= 1'b0;
    end else begin
      lock_q <= lock_m;
      scm_q  <= self_clk_i;
      lock_f <= (lock_m ^ lock_q) | (lock_f & ~clr[4]);
      scm_f  <= (self_clk_i ^ scm_q) | (scm_f & ~clr[1]);
      lvr_f  <= HAS_LVR & (lvr_evt_i | (lvr_f & ~clr[5]));
      irq_q  <= (lock_f & lock_irq_en_i) | (scm_f & scm_irq_en_i);
    end
  end

  assign reg_rdata_o = {2'b00, lvr_f, lock_f, lock_m, track_m, scm_f, self_clk_i};
  assign irq_o       = irq_q;

  // R2: any change of masked lock raises the lock flag
  p_lock_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_m != lock_q) |=> reg_rdata_o[4]);

  // R4: any change of self clock mode raises its flag
  p_scm_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (self_clk_i != scm_q) |=> reg_rdata_o[1]);

  // R3: PLL status hidden in self clock mode
  p_pll_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    self_clk_i |-> (reg_rdata_o[3:2] == 2'b00));

  // R6: writing 0 never clears a set flag
  p_w0_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[4] && reg_sel_i && reg_wr_i && !reg_wdata_i[4]) |=> reg_rdata_o[4]);

  // R7: set beats clear in the same cycle
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((self_clk_i != scm_q) && reg_sel_i && reg_wr_i && reg_wdata_i[1]) |=> reg_rdata_o[1]);

  // R8: no request when both enables were low
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_irq_en_i && !scm_irq_en_i) |=> !irq_o);

endmodule

// File: tb/clk_stat_flags_tb.sv
module clk_stat_flags_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, evt, lock, track, scm, sel, wr, len, sen;
  logic [7:0] wd;
  logic [7:0] rd, rd2;
  logic irq, irq2;

  clk_stat_flags dut_i (
    .clk(clk), .rst_n(rst_n), .lvr_evt_i(evt), .pll_lock_i(lock), .pll_track_i(track),
    .self_clk_i(scm), .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wd),
    .lock_irq_en_i(len), .scm_irq_en_i(sen), .reg_rdata_o(rd), .irq_o(irq));

  clk_stat_flags #(.HAS_LVR(1'b0)) dut_nolvr (
    .clk(clk), .rst_n(rst_n), .lvr_evt_i(evt), .pll_lock_i(lock), .pll_track_i(track),
    .self_clk_i(scm), .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wd),
    .lock_irq_en_i(len), .scm_irq_en_i(sen), .reg_rdata_o(rd2), .irq_o(irq2));

  // shadow stimulus
  logic s_rst, s_evt, s_lock, s_track, s_scm, s_sel, s_wr, s_len, s_sen;
  logic [7:0] s_wd;
  // model state
  logic m_lvr, m_lif, m_sif, m_lq, m_sq, m_irq;

  logic [16:0] q_val[$];
  string       q_tag[$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  initial begin
    rst_n = 0; evt = 0; lock = 0; track = 0; scm = 0; sel = 0; wr = 0; wd = 0; len = 0; sen = 0;
    s_rst = 0; s_evt = 0; s_lock = 0; s_track = 0; s_scm = 0; s_sel = 0; s_wr = 0; s_wd = 0;
    s_len = 0; s_sen = 0;
    m_lvr = 0; m_lif = 0; m_sif = 0; m_lq = 0; m_sq = 0; m_irq = 0;
  end

  task automatic tick(input string tag);
    logic lm, irq_n;
    logic [7:0] c;
    logic [7:0] exp_rd;
    @(negedge clk);
    rst_n = s_rst; evt = s_evt; lock = s_lock; track = s_track; scm = s_scm;
    sel = s_sel; wr = s_wr; wd = s_wd; len = s_len; sen = s_sen;
    lm = s_lock & ~s_scm;
    if (!s_rst) begin
      m_lvr = s_evt; m_lif = 0; m_sif = 0; m_lq = 0; m_sq = 0; m_irq = 0;
    end else begin
      c = (s_sel && s_wr) ? s_wd : 8'h00;
      irq_n = (m_lif & s_len) | (m_sif & s_sen);
      m_lif = (lm ^ m_lq) | (m_lif & ~c[4]);
      m_sif = (s_scm ^ m_sq) | (m_sif & ~c[1]);
      m_lvr = s_evt | (m_lvr & ~c[5]);
      m_lq = lm; m_sq = s_scm; m_irq = irq_n;
    end
    exp_rd = {2'b00, m_lvr, m_lif, lm, s_track & ~s_scm, m_sif, s_scm};
    q_val.push_back({m_irq, exp_rd, exp_rd & 8'hDF});
    q_tag.push_back(tag);
  endtask

  task automatic wr_reg(input string tag, input logic [7:0] v, input logic selv);
    s_sel = selv; s_wr = 1; s_wd = v;
    tick(tag);
    s_sel = 0; s_wr = 0; s_wd = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    logic [16:0] e;
    string t;
    #2;
    if (q_val.size() > 0) begin
      e = q_val.pop_front();
      t = q_tag.pop_front();
      checks += 3;
      if (rd !== e[15:8]) begin
        failures++;
        $display("FAIL %s rdata act=%h exp=%h", t, rd, e[15:8]);
      end
      if (irq !== e[16]) begin
        failures++;
        $display("FAIL %s irq act=%b exp=%b", t, irq, e[16]);
      end
      if (rd2 !== e[7:0]) begin
        failures++;
        $display("FAIL %s rdata_nolvr act=%h exp=%h", t, rd2, e[7:0]);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<=5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    // R1 reset state
    tick("R1"); tick("R1");
    // R5 event captured during reset
    s_evt = 1; tick("R5"); s_evt = 0; tick("R5");
    s_rst = 1; tick("R5");
    wr_reg("R6", 8'h20, 1'b1);
    tick("R6");
    // R2 rising and falling lock
    s_lock = 1; tick("R2"); tick("R2");
    wr_reg("R6", 8'h10, 1'b1);
    tick("R2");
    s_lock = 0; tick("R2");
    wr_reg("R6", 8'h10, 1'b1);
    // R3 track live, no flag
    s_track = 1; tick("R3"); s_track = 0; tick("R3"); s_track = 1; tick("R3");
    s_lock = 1; tick("R3");
    wr_reg("R6", 8'h10, 1'b1);
    // R3/R4 enter self clock mode while locked
    s_scm = 1; tick("R3"); tick("R4");
    // R6 ignored writes
    wr_reg("R6", 8'hFF, 1'b0);
    s_sel = 1; s_wr = 0; s_wd = 8'hFF; tick("R6"); s_sel = 0; s_wd = 0;
    wr_reg("R6", 8'h00, 1'b1);
    wr_reg("R6", 8'h0D, 1'b1);
    tick("R6");
    wr_reg("R6", 8'h12, 1'b1);
    tick("R4");
    // R4 leave self clock mode
    s_scm = 0; tick("R4"); tick("R4");
    wr_reg("R6", 8'h12, 1'b1);
    tick("R6");
    // R7 set wins over clear
    s_lock = 0; tick("R7");
    s_lock = 1; s_sel = 1; s_wr = 1; s_wd = 8'h10; tick("R7");
    s_scm = 1; s_wd = 8'h12; tick("R7");
    s_sel = 0; s_wr = 0; s_wd = 0; tick("R7");
    wr_reg("R6", 8'h12, 1'b1);
    s_scm = 0; tick("R7"); wr_reg("R6", 8'h12, 1'b1); tick("R7");
    // R8 interrupt gating and latency
    s_len = 1; s_lock = 0; tick("R8"); tick("R8"); tick("R8");
    wr_reg("R8", 8'h10, 1'b1);
    tick("R8"); tick("R8");
    s_len = 0; s_sen = 1; s_lock = 1; tick("R8"); tick("R8");
    s_scm = 1; tick("R8"); tick("R8");
    s_sen = 0; tick("R8"); tick("R8");
    s_len = 1; tick("R8");
    wr_reg("R8", 8'h12, 1'b1);
    tick("R8"); tick("R8");
    // R5 event in normal operation
    s_evt = 1; tick("R5"); s_evt = 0; tick("R5");
    wr_reg("R6", 8'hDF, 1'b1);
    tick("R5");
    wr_reg("R6", 8'h20, 1'b1);
    tick("R5");
    // R1 reset again clears flags
    s_scm = 0; tick("R1");
    s_rst = 0; tick("R1"); tick("R1");
    s_rst = 1; tick("R1");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule